// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Unit

This block watches a bank of general-purpose input pins and records interrupt events as sticky status bits, one per pin. Each pad level is brought into the clock domain through a two-flop synchronizer. A third register holds the previous synchronized value, so that edges can be formed. Per-pin configuration inputs pick the trigger type, and a per-pin sense-off input blocks all detection on that pin.

The trigger type comes from two bits per pin: a level-select bit and an invert bit. With level-select low the pin is edge triggered: rising when invert is low, falling when invert is high. With level-select high the pin is level triggered: active-low when invert is low, active-high when invert is high.

Status bits are grouped into 32-bit words: pin p sits in word p/32 at bit p%32. Software clears bits by presenting a word index and a mask with a one-cycle clear strobe. A per-pin enable gates each status bit, and the gated bits are ORed into a registered interrupt output.

Top module: `gpio_trig_unit`

## Requirements
- R1: While reset is high, and on the first sample after it, every status bit reads 0 and the interrupt output is low.
- R2: A pad change passes two synchronizer registers. The earliest status update it can cause happens at the third rising clock edge that samples the new pad value.
- R3: With level-select 0, invert 0 sets the status bit on a rising synchronized edge and invert 1 sets it on a falling one. The opposite edge sets nothing.
- R4: With level-select 1, invert 0 sets the status bit while the synchronized level is 0, and invert 1 sets it while the level is 1.
- R5: In level mode the status bit is set again on every cycle that the active level persists, so a clear has no lasting effect until the level goes away.
- R6: A pin whose sense-off input is 1 never sets its status bit. Turning sensing back on while the pad sits at a steady level produces no edge event.
- R7: A clear strobe with word index w and mask m clears each status bit 32*w+k for which bit k of m is 1. All other bits are unaffected, and a mask of all ones clears the whole word.
- R8: When a clear and a new trigger reach the same pin in the same cycle, the bit ends set.
- R9: The interrupt output is a register loaded with the OR of (status AND enable). It rises one cycle after a pending bit appears and falls one cycle after the last pending bit clears. A status bit whose enable is 0 does not drive it.
- R10: With 95 pins, status is exposed as three 32-bit words and bit 95 always reads 0. A clear strobe with word index 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| sense_off | input | NUM_PINS | 1 blocks detection on the pin |
| level_sel | input | NUM_PINS | 0 edge trigger, 1 level trigger |
| inv_sel | input | NUM_PINS | Polarity select (see R3, R4) |
| irq_en | input | NUM_PINS | Per-pin interrupt enable |
| clr_valid | input | 1 | One-cycle clear strobe |
| clr_word | input | WIDX_W | Status word index to clear |
| clr_mask | input | WORD_W | Write-1-to-clear mask for that word |
| status_o | output | NUM_WORDS*WORD_W | Sticky status words, pin p at bit p |
| irq_o | output | 1 | Registered aggregated interrupt |

## Verification
The hardest case to reach is a clear that lands in exactly the cycle a fresh trigger fires on the same pin. The trigger sits three edges behind the pad change, so random stimulus lines the two up only by chance. The bench therefore raises the pad, waits two edges, and then issues the clear so that both meet at the third edge. A level-mode pin held at its active level gives a second case in which every clear collides with a set. Long random runs then mix sparse pad toggles, changing trigger modes, sense gating and random clears of all four word indices, and compare every cycle against a cycle-level model in the bench.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    typedef struct packed {
        logic cur;
        logic prv;
    } pin_samp_t;

    typedef struct packed {
        logic sense_off;
        logic level;
        logic inv;
    } pin_cfg_t;

    function automatic trig_mode_e mode_of(pin_cfg_t cfg);
        return trig_mode_e'({cfg.level, cfg.inv});
    endfunction

    function automatic logic pin_hit(pin_cfg_t cfg, pin_samp_t s);
        logic h;
        case (mode_of(cfg))
            TRIG_RISE: h = s.cur & ~s.prv;
            TRIG_FALL: h = ~s.cur & s.prv;
            TRIG_LOW:  h = ~s.cur;
            default:   h = s.cur;
        endcase
        return h & ~cfg.sense_off;
    endfunction

endpackage

// File: rtl/gpio_trig_sync.sv
module gpio_trig_sync #(
    parameter int unsigned W = 95
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prv_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign cur_o = sync_q;
    assign prv_o = prev_q;

    // R2: synchronized level trails the pad by two edges
    a_r2_two_stage: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ##1 (cur_o == $past(pad_in, 2)));

    a_r3_prev_tracks: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (prv_o == $past(cur_o)));

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_trig_pkg::*;
#(
    parameter int unsigned W = 95
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prv_i,
    input  logic [W-1:0] sense_off_i,
    input  logic [W-1:0] level_i,
    input  logic [W-1:0] inv_i,
    output logic [W-1:0] hit_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        pin_cfg_t  cfg;
        pin_samp_t smp;
        assign cfg   = '{sense_off: sense_off_i[p], level: level_i[p], inv: inv_i[p]};
        assign smp   = '{cur: cur_i[p], prv: prv_i[p]};
        assign hit_o[p] = pin_hit(cfg, smp);
    end

    // R6: a sensed-off pin never reports a hit
    always_comb begin
        a_r6_gate: assert ((hit_o & sense_off_i) == '0);
    end

endmodule

// File: rtl/gpio_trig_status.sv
module gpio_trig_status #(
    parameter  int unsigned NUM_PINS  = 95,
    parameter  int unsigned WORD_W    = 32,
    localparam int unsigned NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] set_i,
    input  logic                clr_valid_i,
    input  logic [WIDX_W-1:0]   clr_word_i,
    input  logic [WORD_W-1:0]   clr_mask_i,
    output logic [NUM_PINS-1:0] status_o
);
    logic [NUM_PINS-1:0] clr_bits;
    logic [NUM_PINS-1:0] status_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_clr
        assign clr_bits[p] = clr_valid_i
                           && (clr_word_i == WIDX_W'(p / WORD_W))
                           && clr_mask_i[p % WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & ~clr_bits) | set_i;
    end

    assign status_o = status_q;

    // R8: a trigger always leaves its bit set, clear or not
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(set_i) & ~status_q) == '0));

    // R7: cleared bits without a new trigger read 0
    a_r7_clear_takes: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(clr_bits) & ~$past(set_i)) & status_q) == '0));

    // R7: bits outside the mask are held
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(status_q) & ~$past(clr_bits)) & ~status_q) == '0));

endmodule

// File: rtl/gpio_trig_unit.sv
module gpio_trig_unit #(
    parameter  int unsigned NUM_PINS  = 95,
    parameter  int unsigned WORD_W    = 32,
    localparam int unsigned NUM_WORDS = (NUM_PINS + WORD_W - 1) / WORD_W,
    localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned TOTAL_W   = NUM_WORDS * WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] sense_off,
    input  logic [NUM_PINS-1:0] level_sel,
    input  logic [NUM_PINS-1:0] inv_sel,
    input  logic [NUM_PINS-1:0] irq_en,
    input  logic                clr_valid,
    input  logic [WIDX_W-1:0]   clr_word,
    input  logic [WORD_W-1:0]   clr_mask,
    output logic [TOTAL_W-1:0]  status_o,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] cur;
    logic [NUM_PINS-1:0] prv;
    logic [NUM_PINS-1:0] hit;
    logic [NUM_PINS-1:0] status_q;
    logic [NUM_PINS-1:0] pending;
    logic                irq_q;

    gpio_trig_sync #(.W(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .cur_o  (cur),
        .prv_o  (prv)
    );

    gpio_trig_detect #(.W(NUM_PINS)) u_detect (
        .cur_i       (cur),
        .prv_i       (prv),
        .sense_off_i (sense_off),
        .level_i     (level_sel),
        .inv_i       (inv_sel),
        .hit_o       (hit)
    );

    gpio_trig_status #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W)) u_status (
        .clk         (clk),
        .rst         (rst),
        .set_i       (hit),
        .clr_valid_i (clr_valid),
        .clr_word_i  (clr_word),
        .clr_mask_i  (clr_mask),
        .status_o    (status_q)
    );

    assign pending = status_q & irq_en;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pending;
    end

    assign status_o = TOTAL_W'(status_q);
    assign irq_o    = irq_q;

    // R9: output follows the pending set one cycle later
    a_r9_irq_follow: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq_o == $past(|(status_q & irq_en))));

    // R1: first cycle after reset is quiet
    a_r1_quiet: assert property (@(posedge clk)
        rst |=> (!irq_o && status_o == '0));

endmodule

// File: tb/test_gpio_trig_unit.sv
module test_gpio_trig_unit;
    localparam int N   = 95;
    localparam int W   = 32;
    localparam int TOT = 96;

    logic          clk = 1'b0;
    logic          rst;
    logic [N-1:0]  pad_in, sense_off, level_sel, inv_sel, irq_en;
    logic          clr_valid;
    logic [1:0]    clr_word;
    logic [W-1:0]  clr_mask;
    logic [TOT-1:0] status_o;
    logic          irq_o;

    always #5 clk = ~clk;

    gpio_trig_unit i_gpio_trig_unit (
        .clk(clk), .rst(rst), .pad_in(pad_in), .sense_off(sense_off),
        .level_sel(level_sel), .inv_sel(inv_sel), .irq_en(irq_en),
        .clr_valid(clr_valid), .clr_word(clr_word), .clr_mask(clr_mask),
        .status_o(status_o), .irq_o(irq_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    logic [N-1:0] m_s1, m_s2, m_prev, m_st;
    logic         m_irq;

    function automatic logic exp_hit(logic lvl, logic inv, logic off, logic c, logic p);
        logic h;
        if (!lvl) h = inv ? (!c && p) : (c && !p);
        else      h = inv ? c : !c;
        return h && !off;
    endfunction

    function automatic logic [N-1:0] rand_vec();
        logic [TOT-1:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[N-1:0];
    endfunction

    task automatic model_step();
        logic [N-1:0] setv, clrv;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_st = '0; m_irq = 1'b0;
        end else begin
            for (int p = 0; p < N; p++) begin
                setv[p] = exp_hit(level_sel[p], inv_sel[p], sense_off[p], m_s2[p], m_prev[p]);
                clrv[p] = clr_valid && (int'(clr_word) == p / W) && clr_mask[p % W];
            end
            m_irq  = |(m_st & irq_en);
            m_st   = (m_st & ~clrv) | setv;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pad_in;
        end
    endtask

    task automatic compare();
        checks++;
        if (status_o !== {1'b0, m_st}) begin
            errors++;
            $display("FAIL %s status actual=%h expected=%h", cur_req, status_o, {1'b0, m_st});
        end
        checks++;
        if (irq_o !== m_irq) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", cur_req, irq_o, m_irq);
        end
        checks++;
        if (status_o[TOT-1] !== 1'b0) begin
            errors++;
            $display("FAIL R10 top bit actual=%b expected=0", status_o[TOT-1]);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        model_step();
        compare();
        clr_valid = 1'b0;
    endtask

    task automatic expect_bit(string req, int p, logic e);
        checks++;
        if (status_o[p] !== e) begin
            errors++;
            $display("FAIL %s pin %0d actual=%b expected=%b", req, p, status_o[p], e);
        end
    endtask

    task automatic expect_irq(string req, logic e);
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s irq actual=%b expected=%b", req, irq_o, e);
        end
    endtask

    task automatic do_clear(int w, logic [W-1:0] m);
        clr_valid = 1'b1;
        clr_word  = 2'(w);
        clr_mask  = m;
        tick();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; pad_in = '0; sense_off = '0; level_sel = '0; inv_sel = '0;
        irq_en = '1; clr_valid = 1'b0; clr_word = '0; clr_mask = '0;

        // R1 reset state
        cur_req = "R1";
        repeat (3) tick();
        rst = 1'b0;
        tick();
        expect_bit("R1", 0, 1'b0);
        expect_irq("R1", 1'b0);

        // R2 pipeline depth and R3 rising edge
        cur_req = "R2";
        pad_in[5] = 1'b1;
        tick(); tick();
        expect_bit("R2", 5, 1'b0);
        tick();
        expect_bit("R2", 5, 1'b1);
        expect_irq("R9", 1'b0);
        tick();
        expect_irq("R9", 1'b1);

        cur_req = "R7";
        do_clear(0, 32'h0000_0020);
        expect_bit("R7", 5, 1'b0);
        cur_req = "R3";
        pad_in[5] = 1'b0;
        repeat (4) tick();
        expect_bit("R3", 5, 1'b0);

        // R3 falling edge on pin 40
        inv_sel[40] = 1'b1;
        pad_in[40] = 1'b1;
        repeat (4) tick();
        expect_bit("R3", 40, 1'b0);
        pad_in[40] = 1'b0;
        repeat (4) tick();
        expect_bit("R3", 40, 1'b1);
        do_clear(1, 32'h0000_0100);
        expect_bit("R3", 40, 1'b0);

        // R4 level low on pin 70, level high on pin 71
        cur_req = "R4";
        level_sel[70] = 1'b1;
        level_sel[71] = 1'b1; inv_sel[71] = 1'b1;
        tick();
        expect_bit("R4", 70, 1'b1);
        expect_bit("R4", 71, 1'b0);
        pad_in[71] = 1'b1;
        repeat (3) tick();
        expect_bit("R4", 71, 1'b1);

        // R5 level persists through clears
        cur_req = "R5";
        do_clear(2, 32'h0000_0040);
        expect_bit("R5", 70, 1'b1);
        pad_in[70] = 1'b1;
        repeat (3) tick();
        do_clear(2, 32'h0000_0040);
        expect_bit("R5", 70, 1'b0);
        repeat (3) tick();
        expect_bit("R5", 70, 1'b0);

        // R8 clear meets a fresh rising edge
        cur_req = "R8";
        pad_in[5] = 1'b1;
        tick(); tick();
        do_clear(0, 32'hFFFF_FFFF);
        expect_bit("R8", 5, 1'b1);

        // R6 sense gating on pin 12
        cur_req = "R6";
        sense_off[12] = 1'b1;
        pad_in[12] = 1'b1;
        repeat (4) tick();
        expect_bit("R6", 12, 1'b0);
        sense_off[12] = 1'b0;
        repeat (4) tick();
        expect_bit("R6", 12, 1'b0);
        pad_in[12] = 1'b0;
        repeat (3) tick();
        pad_in[12] = 1'b1;
        repeat (3) tick();
        expect_bit("R6", 12, 1'b1);

        // R9 enable gating and release
        cur_req = "R9";
        irq_en = '0;
        tick(); tick();
        expect_irq("R9", 1'b0);
        irq_en[12] = 1'b1;
        tick(); tick();
        expect_irq("R9", 1'b1);
        do_clear(0, 32'hFFFF_FFFF);
        tick();
        expect_irq("R9", 1'b0);

        // R10 word index 3 is ignored, R7 whole-word clear
        cur_req = "R10";
        irq_en = '1;
        pad_in[33] = 1'b1;
        repeat (3) tick();
        expect_bit("R10", 33, 1'b1);
        do_clear(3, 32'hFFFF_FFFF);
        expect_bit("R10", 33, 1'b1);
        cur_req = "R7";
        do_clear(1, 32'hFFFF_FFFF);
        expect_bit("R7", 33, 1'b0);
        expect_bit("R7", 71, 1'b1);

        // random mix
        cur_req = "R3 R4 R5 R6 R7 R8 random";
        for (int c = 0; c < 6000; c++) begin
            if (c % 250 == 0) begin
                level_sel = rand_vec() & rand_vec();
                inv_sel   = rand_vec();
                sense_off = rand_vec() & rand_vec() & rand_vec();
                irq_en    = rand_vec() & rand_vec() & rand_vec();
            end
            pad_in = pad_in ^ (rand_vec() & rand_vec() & rand_vec());
            if ($urandom() % 4 == 0) begin
                clr_valid = 1'b1;
                clr_word  = 2'($urandom() % 4);
                clr_mask  = $urandom();
            end
            tick();
        end

        finish_run();
    end

endmodule